// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock. A slow-clock enable, which pulses at 32.768 kHz in the system clock domain, drives a prescaler. Each time the prescaler wraps it emits a one-second tick. The tick advances a 32-bit seconds counter, and the counter is compared against a programmable alarm value.

A status register holds a tick event flag and an alarm event flag. Each flag has its own interrupt enable, and the two interrupt lines are level outputs. A trim/divider register sets the prescaler period. It can also stretch selected periods by a few slow-clock cycles, so that software can correct a slow-clock source that runs fast. If the divider field is left at zero, the prescaler uses a divider of 32767.

Software reads and writes the registers through a simple 32-bit port. A write is taken in the clock cycle where the write enable is high. A read is combinational from the byte address.

Top module: `sec_rtc`

## Requirements
- R1: Status register layout: bit 3 is the tick interrupt enable, bit 2 is the alarm interrupt enable, bit 1 is the tick flag, bit 0 is the alarm flag, and bits 31:4 read as zero.
- R2: Writing a one to status bit 1 or bit 0 clears that flag. Writing a zero to a flag bit leaves the flag unchanged.
- R3: Status bits 3 and 2 are plain read/write bits, each loaded from the write data on every status write.
- R4: The divider is bits 15:0 of the trim/divider register. The prescaler counts asserted slow-clock enables and ticks on the enable where its count is at or above the period target, then restarts from zero. A period therefore lasts divider+1 enables. A divider field of zero acts as 32767.
- R5: The 32-bit seconds counter reads back its current value, increments by one on each tick, and wraps from 0xFFFFFFFF to 0.
- R6: The alarm flag sets on the clock edge after the counter first becomes equal to the alarm register. Equality that persists does not set the flag again.
- R7: The tick flag sets on the same clock edge at which the tick increments the counter.
- R8: The tick interrupt is the tick flag ANDed with the tick enable, and the alarm interrupt is the alarm flag ANDed with the alarm enable. Both are levels.
- R9: When a flag's set event and a write-one-to-clear of that flag occur in the same cycle, the flag ends up set.
- R10: Trim fields: bits 23:16 hold an extra-cycle count E and bits 31:24 hold an interval N. On every (N+1)th tick, the period that follows is lengthened by E enables. E equal to zero means no trim.
- R11: After reset, all four registers read zero and both interrupts are low. A counter write in the same cycle as a tick wins over the increment.
- R12: Register selection uses address bits 3:2: 0x0 is the counter, 0x4 the alarm, 0x8 the status, 0xC the trim/divider. An access with address bits 1:0 not equal to zero writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_en_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| tick_irq_o | output | 1 | Tick interrupt level |
| alarm_irq_o | output | 1 | Alarm interrupt level |

## Verification
The bench runs the full default period of 32768 enables and checks the count one enable before the tick as well as on it. A design that decoded divider zero literally, or that was off by one in the wrap, would tick at the wrong edge.

Several collisions are driven on purpose:
- A tick in the same cycle as a write-one-to-clear of the tick flag. A design that let the clear win would lose the event.
- A tick in the same cycle as a counter load. A design that let the increment win would show one more than the loaded value.
- A counter wrap from all ones, which a design with a missing carry would get wrong.

The alarm is checked at the exact edge where it sets, so a flag that sets one cycle early or late shows up. Trimmed periods and misaligned accesses are exercised both directly and under random register traffic.

// File: rtl/sec_rtc_pkg.sv
package sec_rtc_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_ALARM  = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_TRIM   = 2'd3
  } reg_sel_e;

  // event index inside the flag bank; status bit = index (flag) or index+2 (enable)
  localparam int EV_ALARM = 0;
  localparam int EV_TICK  = 1;
  localparam int N_EV     = 2;
endpackage

// File: rtl/sec_rtc_prescaler.sv
module sec_rtc_prescaler #(
  parameter int DIV_W   = 16,
  parameter int EXT_W   = 8,
  parameter int IVL_W   = 8,
  parameter int DEF_DIV = 32767
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slow_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [EXT_W-1:0] ext_i,
  input  logic [IVL_W-1:0] ivl_i,
  output logic             tick_o
);
  localparam int PRE_W = DIV_W + 1;

  logic [PRE_W-1:0] pre_q, target;
  logic [DIV_W-1:0] div_eff;
  logic [IVL_W-1:0] ivl_q;
  logic             ext_q;

  assign div_eff = (div_i == '0) ? DIV_W'(DEF_DIV) : div_i;
  assign target  = PRE_W'(div_eff) + (ext_q ? PRE_W'(ext_i) : '0);
  // >= keeps a shrunk divider from stalling the count
  assign tick_o  = slow_en_i && (pre_q >= target);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (slow_en_i) begin
      pre_q <= tick_o ? '0 : pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ivl_q <= '0;
      ext_q <= 1'b0;
    end else if (tick_o) begin
      if (ivl_q >= ivl_i) begin
        ivl_q <= '0;
        ext_q <= 1'b1;
      end else begin
        ivl_q <= ivl_q + IVL_W'(1);
        ext_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sec_rtc_seconds.sv
module sec_rtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic             alarm_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             hit_o
);
  logic match_q, match;

  assign match = (count_o == alarm_o);
  assign hit_o = match && !match_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      alarm_o <= '0;
      match_q <= 1'b1;  // reset equality is not an event
    end else begin
      match_q <= match;
      if (load_i)      count_o <= wdata_i;
      else if (tick_i) count_o <= count_o + CNT_W'(1);
      if (alarm_wr_i)  alarm_o <= wdata_i;
    end
  end
endmodule

// File: rtl/sec_rtc_events.sv
module sec_rtc_events #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_val_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_ev
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_o[i] <= 1'b0;
        en_o[i]   <= 1'b0;
      end else begin
        flag_o[i] <= set_i[i] | (flag_o[i] & ~clr_i[i]);
        if (en_wr_i) en_o[i] <= en_val_i[i];
      end
    end
    assign irq_o[i] = flag_o[i] & en_o[i];
  end
endmodule

// File: rtl/sec_rtc.sv
module sec_rtc
  import sec_rtc_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIV_W   = 16,
  parameter int EXT_W   = 8,
  parameter int DEF_DIV = 32767
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              tick_irq_o,
  output logic              alarm_irq_o
);
  localparam int IVL_W = DATA_W - DIV_W - EXT_W;
  localparam int EXT_LO = DIV_W;
  localparam int IVL_LO = DIV_W + EXT_W;

  logic              aligned, tick, hit;
  reg_sel_e          sel;
  logic              cnt_ld, alm_wr, stat_wr, trim_wr;
  logic [DATA_W-1:0] trim_q, count, alarm;
  logic [N_EV-1:0]   flags, enables, irqs, ev_set, ev_clr;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign cnt_ld  = wr_en_i && aligned && (sel == SEL_COUNT);
  assign alm_wr  = wr_en_i && aligned && (sel == SEL_ALARM);
  assign stat_wr = wr_en_i && aligned && (sel == SEL_STATUS);
  assign trim_wr = wr_en_i && aligned && (sel == SEL_TRIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      trim_q <= '0;
    else if (trim_wr) trim_q <= wdata_i;
  end

  sec_rtc_prescaler #(
    .DIV_W(DIV_W), .EXT_W(EXT_W), .IVL_W(IVL_W), .DEF_DIV(DEF_DIV)
  ) u_pre (
    .clk_i, .rst_ni, .slow_en_i,
    .div_i (trim_q[DIV_W-1:0]),
    .ext_i (trim_q[IVL_LO-1:EXT_LO]),
    .ivl_i (trim_q[DATA_W-1:IVL_LO]),
    .tick_o(tick)
  );

  sec_rtc_seconds #(.CNT_W(DATA_W)) u_sec (
    .clk_i, .rst_ni,
    .tick_i    (tick),
    .load_i    (cnt_ld),
    .alarm_wr_i(alm_wr),
    .wdata_i,
    .count_o   (count),
    .alarm_o   (alarm),
    .hit_o     (hit)
  );

  always_comb begin
    ev_set           = '0;
    ev_set[EV_TICK]  = tick;
    ev_set[EV_ALARM] = hit;
    ev_clr           = stat_wr ? wdata_i[N_EV-1:0] : '0;
  end

  sec_rtc_events #(.N(N_EV)) u_ev (
    .clk_i, .rst_ni,
    .set_i   (ev_set),
    .clr_i   (ev_clr),
    .en_wr_i (stat_wr),
    .en_val_i(wdata_i[2*N_EV-1:N_EV]),
    .flag_o  (flags),
    .en_o    (enables),
    .irq_o   (irqs)
  );

  assign tick_irq_o  = irqs[EV_TICK];
  assign alarm_irq_o = irqs[EV_ALARM];

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      unique case (sel)
        SEL_COUNT:  rdata_o = count;
        SEL_ALARM:  rdata_o = alarm;
        SEL_STATUS: rdata_o = {{(DATA_W-2*N_EV){1'b0}}, enables, flags};
        SEL_TRIM:   rdata_o = trim_q;
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/sec_rtc_checker.sv
module sec_rtc_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick,
  input logic              cnt_ld,
  input logic              stat_wr,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] alarm,
  input logic [1:0]        flags,
  input logic [1:0]        enables,
  input logic              tick_irq_o,
  input logic              alarm_irq_o
);
  a_r2_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[1] && !tick) |=> !flags[1]);

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick |=> flags[1]);

  a_r5_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !cnt_ld && (count == '1)) |=> (count == '0));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !cnt_ld) |=> $stable(count));

  a_r11_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ld |=> (count == $past(wdata_i)));

  a_r6_alarm_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flags[0]) |-> $past(count == alarm));

  a_r8_tick_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enables[1] |-> !tick_irq_o);

  a_r8_alarm_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enables[0] |-> !alarm_irq_o);
endmodule

bind sec_rtc sec_rtc_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .tick, .cnt_ld, .stat_wr, .wdata_i, .count, .alarm,
  .flags, .enables, .tick_irq_o, .alarm_irq_o
);

// File: tb/sec_rtc_bench.sv
`timescale 1ns/1ps
module sec_rtc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tick_irq, alarm_irq;
  int          n_chk = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  sec_rtc u_sec_rtc (
    .clk_i(clk), .rst_ni(rst_n), .slow_en_i(slow_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tick_irq_o(tick_irq), .alarm_irq_o(alarm_irq)
  );

  // reference model built from the requirements
  logic [31:0] m_cnt, m_alarm, m_trim, m_pre, m_tcnt, m_tgt, m_div;
  logic        m_hz, m_al, m_hze, m_ale, m_match, m_ext;
  logic        m_w, m_tk, m_eq, m_aset, m_sw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_alarm = 0; m_trim = 0; m_pre = 0; m_tcnt = 0;
      m_hz = 0; m_al = 0; m_hze = 0; m_ale = 0; m_match = 1; m_ext = 0;
    end else begin
      m_w    = wr_en && (addr[1:0] == 2'b00);
      m_div  = (m_trim[15:0] == 0) ? 32'd32767 : {16'd0, m_trim[15:0]};
      m_tgt  = m_div + (m_ext ? {24'd0, m_trim[23:16]} : 32'd0);
      m_tk   = slow_en && (m_pre >= m_tgt);
      m_eq   = (m_cnt == m_alarm);
      m_aset = m_eq && !m_match;
      m_sw   = m_w && (addr[3:2] == 2'd2);
      m_hz   = (m_hz && !(m_sw && wdata[1])) || m_tk;
      m_al   = (m_al && !(m_sw && wdata[0])) || m_aset;
      if (m_sw) begin m_hze = wdata[3]; m_ale = wdata[2]; end
      m_match = m_eq;
      if (slow_en) m_pre = m_tk ? 0 : m_pre + 1;
      if (m_tk) begin
        if (m_tcnt >= {24'd0, m_trim[31:24]}) begin m_tcnt = 0; m_ext = 1; end
        else begin m_tcnt = m_tcnt + 1; m_ext = 0; end
      end
      if (m_w && addr[3:2] == 2'd0) m_cnt = wdata;
      else if (m_tk) m_cnt = m_cnt + 1;
      if (m_w && addr[3:2] == 2'd1) m_alarm = wdata;
      if (m_w && addr[3:2] == 2'd3) m_trim = wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #0.3;
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_model();
    logic [31:0] v;
    rd(4'h0, v); chk("R5 counter", v, m_cnt);
    rd(4'h4, v); chk("R12 alarm", v, m_alarm);
    rd(4'h8, v); chk("R1 status", v, {28'd0, m_hze, m_ale, m_hz, m_al});
    rd(4'hC, v); chk("R4 trim", v, m_trim);
    chk("R8 tick_irq", {31'd0, tick_irq}, {31'd0, m_hz & m_hze});
    chk("R8 alarm_irq", {31'd0, alarm_irq}, {31'd0, m_al & m_ale});
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R11 reset state
    rd(4'h0, v); chk("R11 reset counter", v, 0);
    rd(4'h4, v); chk("R11 reset alarm", v, 0);
    rd(4'h8, v); chk("R11 reset status", v, 0);
    rd(4'hC, v); chk("R11 reset trim", v, 0);
    chk("R11 reset irqs", {30'd0, tick_irq, alarm_irq}, 0);
    rst_n = 1'b1;

    // R4 default divider: 32768 enables per tick
    slow_en = 1'b1;
    repeat (32767) @(posedge clk);
    @(negedge clk);
    rd(4'h0, v); chk("R4 one enable before tick", v, 0);
    @(negedge clk);
    slow_en = 1'b0;
    rd(4'h0, v); chk("R4 tick at default period", v, 1);
    rd(4'h8, v); chk("R7 tick flag set", v, 32'h2);
    chk("R8 tick irq masked", {31'd0, tick_irq}, 0);
    check_model();

    // R2/R3 flag write-zero and enables
    wr(4'h8, 32'h0);
    rd(4'h8, v); chk("R2 write zero keeps flag", v, 32'h2);
    wr(4'h8, 32'h8);
    rd(4'h8, v); chk("R3 tick enable set", v, 32'hA);
    chk("R8 tick irq level", {31'd0, tick_irq}, 1);
    wr(4'h8, 32'hA);
    rd(4'h8, v); chk("R2 w1c tick flag", v, 32'h8);
    chk("R8 tick irq drops", {31'd0, tick_irq}, 0);
    wr(4'h9, 32'h0);
    rd(4'h8, v); chk("R12 misaligned write ignored", v, 32'h8);
    rd(4'h9, v); chk("R12 misaligned read zero", v, 0);

    // R5 wrap
    wr(4'hC, 32'h1);
    wr(4'h0, 32'hFFFF_FFFF);
    slow_en = 1'b1;
    repeat (2) @(negedge clk);
    slow_en = 1'b0;
    rd(4'h0, v); chk("R5 wrap to zero", v, 0);

    // R9 tick collides with w1c of tick flag
    slow_en = 1'b1;
    @(negedge clk);
    wr(4'h8, 32'hA);
    slow_en = 1'b0;
    rd(4'h8, v); chk("R9 set beats clear", v & 32'h2, 32'h2);
    check_model();

    // R6 alarm timing
    wr(4'h0, 32'd3);
    wr(4'h4, 32'd5);
    wr(4'h8, 32'h7);
    slow_en = 1'b1;
    repeat (4) @(negedge clk);
    slow_en = 1'b0;
    rd(4'h0, v); chk("R6 counter reached alarm", v, 5);
    rd(4'h8, v); chk("R6 flag not yet set", v & 32'hD, 32'h4);
    @(negedge clk);
    rd(4'h8, v); chk("R6 flag set next edge", v & 32'hD, 32'h5);
    chk("R8 alarm irq level", {31'd0, alarm_irq}, 1);

    // R11 load beats tick
    slow_en = 1'b1;
    @(negedge clk);
    wr(4'h0, 32'd100);
    slow_en = 1'b0;
    rd(4'h0, v); chk("R11 load wins over tick", v, 100);

    // R10 trim stretches periods
    wr(4'h0, 32'd0);
    wr(4'hC, 32'h0002_0001);
    slow_en = 1'b1;
    repeat (12) @(negedge clk);
    slow_en = 1'b0;
    rd(4'h0, v); chk("R10 trimmed periods", v, 3);
    wr(4'hC, 32'h0000_0001);
    slow_en = 1'b1;
    repeat (12) @(negedge clk);
    slow_en = 1'b0;
    rd(4'h0, v); chk("R10 zero trim", v, 9);
    check_model();

    // random traffic against the model
    for (int i = 0; i < 15000; i++) begin
      check_model();
      slow_en = ($urandom % 2) == 0;
      wr_en   = ($urandom % 6) == 0;
      begin
        logic [1:0] s;
        s = 2'($urandom % 4);
        addr = {s, (($urandom % 10) == 0) ? 2'b01 : 2'b00};
        case (s)
          2'd0: wdata = m_alarm - 32'($urandom % 4);
          2'd1: wdata = m_cnt + 32'($urandom % 4);
          2'd2: wdata = 32'($urandom % 16);
          default: wdata = {8'($urandom % 3), 8'($urandom % 4),
                            16'((($urandom % 20) == 0) ? 0 : 1 + $urandom % 4)};
        endcase
      end
      @(negedge clk);
      wr_en = 1'b0;
    end
    check_model();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule